// File: doc/BRIEF.md
# VLAN-Aware Ingress Forwarding Filter

This block makes the forwarding decision for each frame that enters a small multi-port Ethernet switch. An upstream parser hands it the destination MAC address, the 16-bit field that follows the source address, the VLAN ID carried by a possible 802.1Q tag, and the number of the port the frame came in on. One clock later the block presents an egress port mask together with a drop flag and a trap-to-host flag.

A frame counts as tagged only when its EtherType field equals a programmable tag-identifier register. A tagged frame takes the VID from its tag, and an untagged frame takes the default VID of its ingress port. The block then looks up that VID's port-membership bitmap in a small table and drops the frame if the ingress port is not a member. Otherwise the egress set is the AND of the ingress port's bridge-domain mask and the membership bitmap, with the ingress port always removed. Two masked destination-MAC match filters send link-local control frames to the host port, and this takes priority over the VLAN decision.

Software programs the configuration through plain register-style inputs and a write port into the membership table. Changing the tag-identifier value lets the same hardware act VLAN-aware (0x8100) or pass standard tagged traffic as untagged (a private value).

Top module: `vlan_ingress_filter`

## Requirements
- R1: A frame is tagged exactly when `hdr_etype` equals `cfg_tpid`. A tagged frame uses `hdr_vid` as its VID.
- R2: A frame whose `hdr_etype` differs from `cfg_tpid` is untagged. This includes 0x8100 when `cfg_tpid` holds another value.
- R3: An untagged frame from port p uses the default VID in `cfg_pvid[12p+11:12p]`.
- R4: The membership table is indexed by the low `TBL_BITS` bits of the VID, and bit p of an entry marks port p as a member. A VID with any bit set above those bits has no members. A non-trapped frame whose ingress port is not a member gives drop=1, trap=0 and mask=0.
- R5: A forwarded frame from port p gets mask = `cfg_dom[N*p+N-1:N*p]` AND the VLAN bitmap AND NOT(bit p), with drop=0 and trap=0. A mask of zero is not a drop.
- R6: A frame traps when, for either filter k, (dmac AND mask_k) equals (value_k AND mask_k). A trapped frame gives trap=1 and drop=0, and its mask holds only the host port bit (`HOST_PORT`, default 4). This overrides the VLAN membership check.
- R7: The ingress port's own bit is never set in the output mask. This includes a trap that arrives on the host port, which gives mask 0.
- R8: An ingress port number of `NPORTS` or more gives drop=1, trap=0 and mask=0, even when a trap filter matches.
- R9: Table entries reset to all zero. A write with `cfg_vlan_we` takes effect at the clock edge. A lookup in the same cycle as the write still sees the old content.
- R10: `out_valid` rises exactly one cycle after a cycle with `hdr_valid` high and is low otherwise. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_port | input | PW ($clog2(NPORTS)) | Ingress port number |
| hdr_dmac | input | 48 | Destination MAC |
| hdr_etype | input | 16 | EtherType / tag identifier field |
| hdr_vid | input | VID_W | VID from the tag position |
| cfg_tpid | input | 16 | Tag identifier that marks a tagged frame |
| cfg_pvid | input | NPORTS*VID_W | Per-port default VID |
| cfg_dom | input | NPORTS*NPORTS | Per-port bridge-domain mask |
| cfg_trap_val0 | input | 48 | Trap filter 0 value |
| cfg_trap_msk0 | input | 48 | Trap filter 0 mask |
| cfg_trap_val1 | input | 48 | Trap filter 1 value |
| cfg_trap_msk1 | input | 48 | Trap filter 1 mask |
| cfg_vlan_we | input | 1 | Membership table write enable |
| cfg_vlan_addr | input | TBL_BITS | Membership table write index |
| cfg_vlan_map | input | NPORTS | Membership bitmap to write |
| out_valid | output | 1 | Decision valid |
| out_mask | output | NPORTS | Egress port mask |
| out_drop | output | 1 | Frame dropped at ingress |
| out_trap | output | 1 | Frame trapped to host |

## Verification
The block's only state is the membership table and the output register. A corrupted or stale table entry therefore shows up on the very next decision for that VID, one cycle after the header strobe. It appears as a wrong drop or a wrong egress mask. A mistake in tag classification looks the same, because the frame then uses the default VID instead of the tagged one. The tests pick VIDs whose bitmaps give different results for a member and a non-member port, so each such fault changes a visible mask bit or the drop flag. Writes that land in the same cycle as a lookup are also tested, so a table that forwards new data too early is caught.

// File: rtl/vlan_ingress_filter.sv
module vlan_ingress_filter #(
  parameter int NPORTS    = 5,
  parameter int VID_W     = 12,
  parameter int TBL_BITS  = 4,
  parameter int HOST_PORT = 4,
  localparam int PW       = $clog2(NPORTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hdr_valid,
  input  logic [PW-1:0]            hdr_port,
  input  logic [47:0]              hdr_dmac,
  input  logic [15:0]              hdr_etype,
  input  logic [VID_W-1:0]         hdr_vid,
  input  logic [15:0]              cfg_tpid,
  input  logic [NPORTS*VID_W-1:0]  cfg_pvid,
  input  logic [NPORTS*NPORTS-1:0] cfg_dom,
  input  logic [47:0]              cfg_trap_val0,
  input  logic [47:0]              cfg_trap_msk0,
  input  logic [47:0]              cfg_trap_val1,
  input  logic [47:0]              cfg_trap_msk1,
  input  logic                     cfg_vlan_we,
  input  logic [TBL_BITS-1:0]      cfg_vlan_addr,
  input  logic [NPORTS-1:0]        cfg_vlan_map,
  output logic                     out_valid,
  output logic [NPORTS-1:0]        out_mask,
  output logic                     out_drop,
  output logic                     out_trap
);
  localparam int DEPTH = 1 << TBL_BITS;
  localparam logic [PW:0] NP = (PW+1)'(NPORTS);
  localparam logic [NPORTS-1:0] ONE = 1;
  localparam logic [NPORTS-1:0] HOST_BIT = ONE << HOST_PORT;

  logic [NPORTS-1:0] member_tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) member_tbl[i] <= '0;
    end else if (cfg_vlan_we) begin
      member_tbl[cfg_vlan_addr] <= cfg_vlan_map;
    end
  end

  logic              port_ok, is_tagged, trap_hit, is_member;
  logic [PW-1:0]     port_idx;
  logic [VID_W-1:0]  vid;
  logic [NPORTS-1:0] in_bit, vmap, dom_row;

  assign port_ok   = {1'b0, hdr_port} < NP;
  assign port_idx  = port_ok ? hdr_port : '0;
  assign in_bit    = ONE << port_idx;
  assign is_tagged = (hdr_etype == cfg_tpid);
  assign vid       = is_tagged ? hdr_vid : cfg_pvid[port_idx*VID_W +: VID_W];
  assign vmap      = (vid[VID_W-1:TBL_BITS] == '0) ? member_tbl[vid[TBL_BITS-1:0]] : '0;
  assign is_member = |(vmap & in_bit);
  assign dom_row   = cfg_dom[port_idx*NPORTS +: NPORTS];
  assign trap_hit  = (((hdr_dmac ^ cfg_trap_val0) & cfg_trap_msk0) == '0) ||
                     (((hdr_dmac ^ cfg_trap_val1) & cfg_trap_msk1) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_drop  <= 1'b0;
      out_trap  <= 1'b0;
    end else begin
      out_valid <= hdr_valid;
      if (hdr_valid) begin
        if (!port_ok) begin
          out_mask <= '0;
          out_drop <= 1'b1;
          out_trap <= 1'b0;
        end else if (trap_hit) begin
          out_mask <= HOST_BIT & ~in_bit;
          out_drop <= 1'b0;
          out_trap <= 1'b1;
        end else if (!is_member) begin
          out_mask <= '0;
          out_drop <= 1'b1;
          out_trap <= 1'b0;
        end else begin
          out_mask <= dom_row & vmap & ~in_bit;
          out_drop <= 1'b0;
          out_trap <= 1'b0;
        end
      end
    end
  end

  assert_drop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> (out_mask == '0 && !out_trap));

  assert_trap_host_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> ((out_mask & ~HOST_BIT) == '0 && !out_drop));

  assert_no_reflect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & $past(in_bit)) == '0));

  assert_bad_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !port_ok) |=> (out_drop && !out_trap));

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !out_valid);
endmodule

// File: tb/vlan_ingress_filter_bench.sv
module vlan_ingress_filter_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, hdr_valid, cfg_vlan_we;
  logic [2:0]  hdr_port;
  logic [47:0] hdr_dmac;
  logic [15:0] hdr_etype, cfg_tpid;
  logic [11:0] hdr_vid;
  logic [59:0] cfg_pvid;
  logic [24:0] cfg_dom;
  logic [47:0] cfg_trap_val0, cfg_trap_msk0, cfg_trap_val1, cfg_trap_msk1;
  logic [3:0]  cfg_vlan_addr;
  logic [4:0]  cfg_vlan_map;
  logic        out_valid, out_drop, out_trap;
  logic [4:0]  out_mask;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [47:0] PLAIN = 48'h0011_2233_4455;
  localparam logic [47:0] LL0   = 48'h0180_C200_000E;

  vlan_ingress_filter u_vlan_ingress_filter (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_port(hdr_port),
    .hdr_dmac(hdr_dmac), .hdr_etype(hdr_etype), .hdr_vid(hdr_vid),
    .cfg_tpid(cfg_tpid), .cfg_pvid(cfg_pvid), .cfg_dom(cfg_dom),
    .cfg_trap_val0(cfg_trap_val0), .cfg_trap_msk0(cfg_trap_msk0),
    .cfg_trap_val1(cfg_trap_val1), .cfg_trap_msk1(cfg_trap_msk1),
    .cfg_vlan_we(cfg_vlan_we), .cfg_vlan_addr(cfg_vlan_addr), .cfg_vlan_map(cfg_vlan_map),
    .out_valid(out_valid), .out_mask(out_mask), .out_drop(out_drop), .out_trap(out_trap));

  task automatic check(string req, logic v, logic [4:0] m, logic d, logic t);
    checks++;
    if (out_valid !== v || out_mask !== m || out_drop !== d || out_trap !== t) begin
      fails++;
      $display("FAIL %s: got v=%b mask=%b drop=%b trap=%b, expected v=%b mask=%b drop=%b trap=%b",
               req, out_valid, out_mask, out_drop, out_trap, v, m, d, t);
    end
  endtask

  task automatic send(logic [2:0] p, logic [47:0] da, logic [15:0] et, logic [11:0] v);
    @(negedge clk);
    hdr_port = p; hdr_dmac = da; hdr_etype = et; hdr_vid = v; hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic tbl_write(logic [3:0] a, logic [4:0] m);
    @(negedge clk);
    cfg_vlan_we = 1; cfg_vlan_addr = a; cfg_vlan_map = m;
    @(negedge clk);
    cfg_vlan_we = 0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R10 reset", 0, 5'b0, 0, 0);
    send(3'd0, PLAIN, 16'h0800, 12'd0);
    check("R9 table zero after reset", 1, 5'b0, 1, 0);
  endtask

  task automatic test_forward;
    send(3'd0, PLAIN, 16'h0800, 12'd9);
    check("R3 R5 R7 untagged pvid forward", 1, 5'b10110, 0, 0);
    send(3'd1, PLAIN, 16'h8100, 12'd5);
    check("R1 tagged vid5", 1, 5'b00001, 0, 0);
    send(3'd3, PLAIN, 16'h0800, 12'd0);
    check("R5 domain AND gives empty mask", 1, 5'b00000, 0, 0);
  endtask

  task automatic test_member_drop;
    send(3'd1, PLAIN, 16'h8100, 12'd2);
    check("R4 non-member drop", 1, 5'b0, 1, 0);
    send(3'd0, PLAIN, 16'h8100, 12'd7);
    check("R4 unconfigured vid drop", 1, 5'b0, 1, 0);
    send(3'd0, PLAIN, 16'h8100, 12'h015);
    check("R4 vid above table drop", 1, 5'b0, 1, 0);
  endtask

  task automatic test_tpid;
    @(negedge clk); cfg_tpid = 16'h88A8;
    send(3'd2, PLAIN, 16'h8100, 12'd5);
    check("R2 0x8100 untagged under custom tpid", 1, 5'b01001, 0, 0);
    send(3'd0, PLAIN, 16'h88A8, 12'd5);
    check("R1 custom tpid tagged", 1, 5'b00010, 0, 0);
    @(negedge clk); cfg_tpid = 16'h8100;
  endtask

  task automatic test_trap;
    send(3'd0, LL0, 16'h0800, 12'd0);
    check("R6 filter0 trap", 1, 5'b10000, 0, 1);
    send(3'd1, LL0, 16'h8100, 12'd2);
    check("R6 trap overrides membership", 1, 5'b10000, 0, 1);
    send(3'd0, 48'h011B_1912_3456, 16'h0800, 12'd0);
    check("R6 filter1 trap", 1, 5'b10000, 0, 1);
    send(3'd0, 48'h0180_C200_0010, 16'h0800, 12'd0);
    check("R6 masked mismatch no trap", 1, 5'b10110, 0, 0);
    send(3'd4, LL0, 16'h0800, 12'd0);
    check("R7 trap from host port", 1, 5'b00000, 0, 1);
  endtask

  task automatic test_bad_port;
    send(3'd6, LL0, 16'h0800, 12'd0);
    check("R8 out-of-range port", 1, 5'b0, 1, 0);
  endtask

  task automatic test_timing_and_write;
    @(negedge clk);
    check("R10 idle valid low", 0, 5'b0, 1, 0);
    @(negedge clk);
    cfg_vlan_we = 1; cfg_vlan_addr = 4'd5; cfg_vlan_map = 5'b00000;
    hdr_port = 3'd1; hdr_dmac = PLAIN; hdr_etype = 16'h8100; hdr_vid = 12'd5; hdr_valid = 1;
    @(negedge clk);
    cfg_vlan_we = 0; hdr_valid = 0;
    check("R9 same-cycle write sees old entry", 1, 5'b00001, 0, 0);
    send(3'd1, PLAIN, 16'h8100, 12'd5);
    check("R9 new entry after write", 1, 5'b0, 1, 0);
  endtask

  initial begin
    rst_n = 0; hdr_valid = 0; cfg_vlan_we = 0; hdr_port = 0; hdr_dmac = 0;
    hdr_etype = 0; hdr_vid = 0; cfg_vlan_addr = 0; cfg_vlan_map = 0;
    cfg_tpid = 16'h8100;
    cfg_pvid = {12'd1, 12'd2, 12'd2, 12'd1, 12'd1};
    cfg_dom  = {5'h1F, 5'b11000, 5'h1F, 5'h1F, 5'h1F};
    cfg_trap_val0 = 48'h0180_C200_0000; cfg_trap_msk0 = 48'hFFFF_FFFF_FFF0;
    cfg_trap_val1 = 48'h011B_1900_0000; cfg_trap_msk1 = 48'hFFFF_FF00_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset;
    tbl_write(4'd1, 5'b10111);
    tbl_write(4'd2, 5'b01101);
    tbl_write(4'd5, 5'b00011);
    test_forward;
    test_member_drop;
    test_tpid;
    test_trap;
    test_bad_port;
    test_timing_and_write;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule